// File: doc/BRIEF.md
# Instruction-Tagging Sample Profiler

This block watches the fetch stream of a processor core. After a programmable number of fetched instructions plus a small pseudo-random offset, it marks one fetched instruction as the profiled one. It then follows only that instruction as it passes the map, issue, execute and completion points of the pipeline. The record it builds belongs to that instruction alone: its own PC, its fetch and data-side miss flags, its memory address, its branch outcome and the branch history at that point, and the cycle counts between consecutive stages. Because the record comes from the chosen instruction and not from whatever was in flight when a counter expired, the result has no skew or smear.

When the marked instruction leaves the pipeline, by retiring or by being squashed, the unit raises an interrupt and freezes the record. Software reads the record through a four-entry read port and pulses a re-arm input to start the next sampling interval. Only one instruction is tracked at a time. The fetch interface is observe-only: the block has no ready signal and never stalls fetch. Every cycle with `fetch_valid` high counts as one fetched instruction. The per-stage strobes are plain valid pulses that carry the tag bit the pipeline propagated from `fetch_tag`.

Top module: `itag_profiler`

## Requirements
- R1: After reset nothing is tagged and `irq` is low until the first `sw_rearm` pulse is accepted.
- R2: An accepted re-arm loads the interval counter with `base_period` plus the low RAND_W (default 4) bits of a 16-bit LFSR. The LFSR is seeded with 16'hB5A3 at reset and shifts left with new bit 0 = b15^b13^b12^b10. It steps once per accepted re-arm, after its value has been used, so the first reload uses the seed.
- R3: The counter decrements only on cycles with `fetch_valid` high. The fetch seen while it is zero is tagged, with `fetch_tag` high in that same cycle. A reload value N therefore lets N fetches pass and tags the next one.
- R4: At most one instruction is tracked. No tag is issued between a tag and the next accepted re-arm. A re-arm is accepted only when no instruction is tracked and the unit is idle or holding a record. A re-arm in the same cycle as the completion strobe is ignored.
- R5: `rd_sel`=0 returns the PC of the tagged fetch. Flag bit 1 holds `fetch_icmiss` from that fetch.
- R6: On the tagged execute strobe the unit captures the data address (`rd_sel`=1) and these flags (`rd_sel`=2): bit 5 memory operation, bit 2 D-cache miss, bit 6 branch, bit 4 taken, bit 3 mispredict. Flag bits [23:16] hold the branch history register as it stood before that strobe. This register shifts in the taken bit of every executed branch, tagged or not, with the newest at bit 0.
- R7: `rd_sel`=3 holds four LAT_W-bit (default 8) latencies: fetch-to-map in [7:0], map-to-issue in [15:8], issue-to-execute in [23:16] and execute-to-retire in [31:24]. Each is the number of cycles between the tagged strobes of the two stages. Flag bits [11:8] mark each field valid, in the same order.
- R8: A latency longer than 2^LAT_W-1 cycles reads as 2^LAT_W-1.
- R9: A completion strobe with `done_retired`=1 sets flag bit 0 and the execute-to-retire field. With `done_retired`=0 (aborted), flag bit 0 stays clear and every stage the instruction did not reach reads zero with its valid bit clear.
- R10: `irq` rises in the cycle after the tagged completion strobe. It stays high, with the record unchanged, until the next accepted re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | One instruction fetched this cycle |
| fetch_pc | input | PC_W | PC of the fetched instruction |
| fetch_icmiss | input | 1 | Fetched instruction missed the I-cache |
| fetch_tag | output | 1 | This fetch is the profiled instruction |
| map_valid | input | 1 | An instruction was mapped |
| map_tag | input | 1 | Mapped instruction carries the tag |
| issue_valid | input | 1 | An instruction was issued |
| issue_tag | input | 1 | Issued instruction carries the tag |
| exec_valid | input | 1 | An instruction executed |
| exec_tag | input | 1 | Executed instruction carries the tag |
| exec_is_mem | input | 1 | Executed instruction accesses memory |
| exec_daddr | input | ADDR_W | Data address of the memory access |
| exec_dcmiss | input | 1 | Memory access missed the D-cache |
| exec_is_branch | input | 1 | Executed instruction is a conditional branch |
| exec_taken | input | 1 | Branch direction, 1 = taken |
| exec_mispredict | input | 1 | Branch was mispredicted |
| done_valid | input | 1 | An instruction left the pipeline |
| done_tag | input | 1 | Departing instruction carries the tag |
| done_retired | input | 1 | 1 = retired, 0 = aborted |
| base_period | input | CNT_W | Base sampling interval in fetches |
| sw_rearm | input | 1 | Clear the record and start a new interval |
| rd_sel | input | 2 | Record read select |
| rd_data | output | 32 | Selected record word |
| irq | output | 1 | Record valid, request for service |

## Verification
The completion of the tracked instruction and a software re-arm can land in the same cycle. If the block honoured both, it would start counting again while freezing a fresh record, and it would step the LFSR. The bench pulses `sw_rearm` in the exact cycle of the tagged completion strobe. It then requires `irq` to stay high, the record to read back intact, and the tag position of the following interval to follow the unstepped LFSR sequence. A second overlap is the tagged execute strobe sharing history updates with untagged branch executions. The bench interleaves untagged branches and judges the captured history against its own shift model.

// File: rtl/itp_pkg.sv
package itp_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_COUNT  = 2'd1,
    S_FLIGHT = 2'd2,
    S_HELD   = 2'd3
  } samp_state_e;

  localparam logic [15:0] LFSR_SEED = 16'hB5A3;
  localparam int NUM_SEG = 4;
endpackage

// File: rtl/itp_lfsr.sv
module itp_lfsr #(
  parameter int          OUT_W = 4,
  parameter logic [15:0] SEED  = itp_pkg::LFSR_SEED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [OUT_W-1:0] rnd
);
  logic [15:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sr_q <= SEED;
    else if (step) sr_q <= {sr_q[14:0], sr_q[15] ^ sr_q[13] ^ sr_q[12] ^ sr_q[10]};
  end

  assign rnd = sr_q[OUT_W-1:0];

  // R2
  lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> sr_q != $past(sr_q));
endmodule

// File: rtl/itp_sampler.sv
module itp_sampler
  import itp_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int RAND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic             sw_rearm,
  input  logic             done_hit,
  input  logic [CNT_W-1:0] base_period,
  output logic             fetch_tag,
  output logic             in_flight,
  output logic             held
);
  samp_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RAND_W-1:0] rnd;
  logic [CNT_W-1:0] reload;
  logic             rearm_ok;

  assign rearm_ok = sw_rearm && (st_q == S_IDLE || st_q == S_HELD);

  itp_lfsr #(.OUT_W(RAND_W)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (rearm_ok),
    .rnd  (rnd)
  );

  assign reload    = base_period + {{(CNT_W-RAND_W){1'b0}}, rnd};
  assign fetch_tag = (st_q == S_COUNT) && fetch_valid && (cnt_q == '0);
  assign in_flight = (st_q == S_FLIGHT);
  assign held      = (st_q == S_HELD);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE, S_HELD: begin
        if (rearm_ok) begin
          st_d  = S_COUNT;
          cnt_d = reload;
        end
      end
      S_COUNT: begin
        if (fetch_valid) begin
          if (cnt_q == '0) st_d  = S_FLIGHT;
          else             cnt_d = cnt_q - 1'b1;
        end
      end
      S_FLIGHT: begin
        if (done_hit) st_d = S_HELD;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_COUNT && fetch_valid && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R4
  tag_enters_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_tag |=> in_flight);
  // R4
  rearm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && !done_hit) |=> in_flight);
  // R2
  rearm_starts_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_ok |=> (st_q == S_COUNT));
endmodule

// File: rtl/itp_latency.sv
module itp_latency #(
  parameter int LAT_W = 8,
  parameter int NSEG  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       in_flight,
  input  logic [NSEG-1:0]            ev,
  output logic [NSEG-1:0][LAT_W-1:0] lat,
  output logic [NSEG-1:0]            lat_vld
);
  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  logic [LAT_W-1:0] seg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seg_q <= '0;
    else if (start)            seg_q <= LAT_ONE;
    else if (in_flight) begin
      if (|ev)                 seg_q <= LAT_ONE;
      else if (seg_q != LAT_MAX) seg_q <= seg_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [LAT_W-1:0] l_q;
    logic             v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        l_q <= '0;
        v_q <= 1'b0;
      end else if (start) begin
        l_q <= '0;
        v_q <= 1'b0;
      end else if (ev[k]) begin
        l_q <= seg_q;
        v_q <= 1'b1;
      end
    end
    assign lat[k]     = l_q;
    assign lat_vld[k] = v_q;
  end

  // R8
  lat_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && !start && ev == '0 && seg_q == LAT_MAX) |=> seg_q == LAT_MAX);
endmodule

// File: rtl/itag_profiler.sv
module itag_profiler
  import itp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int RAND_W = 4,
  parameter int LAT_W  = 8,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic              fetch_icmiss,
  output logic              fetch_tag,
  input  logic              map_valid,
  input  logic              map_tag,
  input  logic              issue_valid,
  input  logic              issue_tag,
  input  logic              exec_valid,
  input  logic              exec_tag,
  input  logic              exec_is_mem,
  input  logic [ADDR_W-1:0] exec_daddr,
  input  logic              exec_dcmiss,
  input  logic              exec_is_branch,
  input  logic              exec_taken,
  input  logic              exec_mispredict,
  input  logic              done_valid,
  input  logic              done_tag,
  input  logic              done_retired,
  input  logic [CNT_W-1:0]  base_period,
  input  logic              sw_rearm,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam int DATA_W = 32;
  localparam int NSEG   = NUM_SEG;

  logic in_flight, held;
  logic map_hit, issue_hit, exec_hit, done_hit;
  logic [NSEG-1:0]            ev;
  logic [NSEG-1:0][LAT_W-1:0] lat;
  logic [NSEG-1:0]            lat_vld;

  logic [PC_W-1:0]   pc_q;
  logic [ADDR_W-1:0] daddr_q;
  logic              icm_q, mem_q, dcm_q, br_q, tk_q, mp_q, ret_q;
  logic [HIST_W-1:0] hist_live, hist_q;
  logic [DATA_W-1:0] flags;

  assign map_hit   = in_flight && map_valid   && map_tag;
  assign issue_hit = in_flight && issue_valid && issue_tag;
  assign exec_hit  = in_flight && exec_valid  && exec_tag;
  assign done_hit  = in_flight && done_valid  && done_tag;
  assign ev        = {done_hit && done_retired, exec_hit, issue_hit, map_hit};

  itp_sampler #(.CNT_W(CNT_W), .RAND_W(RAND_W)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_valid(fetch_valid),
    .sw_rearm   (sw_rearm),
    .done_hit   (done_hit),
    .base_period(base_period),
    .fetch_tag  (fetch_tag),
    .in_flight  (in_flight),
    .held       (held)
  );

  itp_latency #(.LAT_W(LAT_W), .NSEG(NSEG)) u_latency (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fetch_tag),
    .in_flight(in_flight),
    .ev       (ev),
    .lat      (lat),
    .lat_vld  (lat_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_live <= '0;
    else if (exec_valid && exec_is_branch) hist_live <= {hist_live[HIST_W-2:0], exec_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0; daddr_q <= '0; hist_q <= '0;
      icm_q <= 1'b0; mem_q <= 1'b0; dcm_q <= 1'b0;
      br_q <= 1'b0; tk_q <= 1'b0; mp_q <= 1'b0; ret_q <= 1'b0;
    end else if (fetch_tag) begin
      pc_q <= fetch_pc; icm_q <= fetch_icmiss;
      daddr_q <= '0; hist_q <= '0;
      mem_q <= 1'b0; dcm_q <= 1'b0; br_q <= 1'b0;
      tk_q <= 1'b0; mp_q <= 1'b0; ret_q <= 1'b0;
    end else begin
      if (exec_hit) begin
        daddr_q <= exec_daddr;   mem_q <= exec_is_mem;  dcm_q <= exec_dcmiss;
        br_q    <= exec_is_branch; tk_q <= exec_taken;  mp_q  <= exec_mispredict;
        hist_q  <= hist_live;
      end
      if (done_hit && done_retired) ret_q <= 1'b1;
    end
  end

  always_comb begin
    flags = '0;
    flags[0] = ret_q;
    flags[1] = icm_q;
    flags[2] = dcm_q;
    flags[3] = mp_q;
    flags[4] = tk_q;
    flags[5] = mem_q;
    flags[6] = br_q;
    flags[8 +: NSEG]    = lat_vld;
    flags[16 +: HIST_W] = hist_q;
  end

  always_comb begin
    unique case (rd_sel)
      2'd0:    rd_data = DATA_W'(pc_q);
      2'd1:    rd_data = DATA_W'(daddr_q);
      2'd2:    rd_data = flags;
      default: rd_data = DATA_W'(lat);
    endcase
  end

  assign irq = held;

  // R10
  irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_valid && done_tag));
  // R10
  record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (!irq || ($stable(pc_q) && $stable(daddr_q) && $stable(lat))));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !fetch_tag);
endmodule

// File: tb/test_itag_profiler.sv
module test_itag_profiler;
  localparam time HALF = 10ns;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] daddr;
    logic [31:0] flags;
    logic [31:0] lat;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 0, fetch_icmiss = 0;
  logic [31:0] fetch_pc = '0;
  logic        fetch_tag;
  logic        map_valid = 0, map_tag = 0, issue_valid = 0, issue_tag = 0;
  logic        exec_valid = 0, exec_tag = 0, exec_is_mem = 0, exec_dcmiss = 0;
  logic        exec_is_branch = 0, exec_taken = 0, exec_mispredict = 0;
  logic [31:0] exec_daddr = '0;
  logic        done_valid = 0, done_tag = 0, done_retired = 0;
  logic [11:0] base_period = '0;
  logic        sw_rearm = 0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0, errors = 0;
  int pushed = 0, popped = 0;
  logic [15:0] lfsr_m = 16'hB5A3;
  logic [7:0]  hist_m = '0;
  rec_t        sb_q[$];
  bit          finished = 0;

  always #HALF clk = ~clk;

  itag_profiler i_itag_profiler (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_icmiss(fetch_icmiss), .fetch_tag(fetch_tag),
    .map_valid(map_valid), .map_tag(map_tag), .issue_valid(issue_valid), .issue_tag(issue_tag),
    .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_is_mem(exec_is_mem), .exec_daddr(exec_daddr),
    .exec_dcmiss(exec_dcmiss), .exec_is_branch(exec_is_branch), .exec_taken(exec_taken),
    .exec_mispredict(exec_mispredict),
    .done_valid(done_valid), .done_tag(done_tag), .done_retired(done_retired),
    .base_period(base_period), .sw_rearm(sw_rearm), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  function automatic logic [7:0] sat8(input int d);
    return (d > 255) ? 8'd255 : d[7:0];
  endfunction

  // Driver: one sampling interval; dm/di/dx = stage gaps (-1 = not reached), dd = gap to completion
  task automatic run_sample(input int base, input int skip_mod, input int dm, input int di,
                            input int dx, input int dd, input bit ret, input bit icm,
                            input bit mem, input bit dcm, input bit br, input bit tk,
                            input bit mp, input logic [31:0] da, input bit rearm_at_done);
    int n, idx, c, got, tm, ti, te, tlast, tdone;
    bit v;
    rec_t e;
    logic [7:0] hsnap;
    logic [3:0] lv;
    logic [7:0] l0, l1, l2, l3;
    @(negedge clk);
    base_period = base[11:0];
    sw_rearm = 1;
    @(negedge clk);
    sw_rearm = 0;
    n = base + int'(lfsr_m[3:0]);
    lfsr_m = lfsr_next(lfsr_m);
    idx = 0; c = 0; got = -1;
    while (got == -1 && idx <= n + 2) begin
      v = !(skip_mod > 0 && (c % skip_mod) == skip_mod - 1);
      fetch_valid = v;
      fetch_pc = 32'h1000 + 32'(4 * idx);
      fetch_icmiss = (v && idx == n) ? icm : 1'b0;
      #1;
      if (fetch_tag) got = v ? idx : -2;
      if (v) idx++;
      c++;
      @(negedge clk);
    end
    fetch_valid = 0; fetch_icmiss = 0;
    check("R3 tag position", 32'(got), 32'(n));
    if (got != n) return;

    tm = (dm >= 0) ? dm : -1;
    ti = (tm >= 0 && di >= 0) ? tm + di : -1;
    te = (ti >= 0 && dx >= 0) ? ti + dx : -1;
    tlast = (te >= 0) ? te : (ti >= 0) ? ti : (tm >= 0) ? tm : 0;
    tdone = tlast + dd;
    lv = {ret && te >= 0, te >= 0, ti >= 0, tm >= 0};
    l0 = (tm >= 0) ? sat8(dm) : 8'd0;
    l1 = (ti >= 0) ? sat8(di) : 8'd0;
    l2 = (te >= 0) ? sat8(dx) : 8'd0;
    l3 = (lv[3]) ? sat8(dd) : 8'd0;
    hsnap = '0;
    for (int t = 1; t <= tdone; t++) begin
      if (t == te) hsnap = hist_m;
      if (t == te && br) hist_m = {hist_m[6:0], tk};
      else if (t != te && t % 3 == 1) hist_m = {hist_m[6:0], 1'((t / 3) % 2)};
    end
    e.pc    = 32'h1000 + 32'(4 * n);
    e.daddr = (te >= 0) ? da : '0;
    e.flags = {8'd0, hsnap, 4'd0, lv, 1'b0,
               (te >= 0) && br, (te >= 0) && mem, (te >= 0) && tk,
               (te >= 0) && mp, (te >= 0) && dcm, icm, lv[3]};
    e.lat   = {l3, l2, l1, l0};
    sb_q.push_back(e);
    pushed++;

    for (int t = 1; t <= tdone; t++) begin
      map_valid   = (t == tm); map_tag   = (t == tm);
      issue_valid = (t == ti); issue_tag = (t == ti);
      exec_valid = 0; exec_tag = 0; exec_is_mem = 0; exec_dcmiss = 0;
      exec_is_branch = 0; exec_taken = 0; exec_mispredict = 0; exec_daddr = '0;
      if (t == te) begin
        exec_valid = 1; exec_tag = 1; exec_is_mem = mem; exec_dcmiss = dcm;
        exec_is_branch = br; exec_taken = tk; exec_mispredict = mp; exec_daddr = da;
      end else if (t % 3 == 1) begin
        exec_valid = 1; exec_is_branch = 1; exec_taken = 1'((t / 3) % 2);
      end
      done_valid = (t == tdone); done_tag = (t == tdone); done_retired = ret;
      sw_rearm = rearm_at_done && (t == tdone);
      if (t == tdone) begin
        #1;
        check("R10 irq low before completion edge", 32'(irq), 32'd0);
      end
      @(negedge clk);
    end
    map_valid = 0; map_tag = 0; issue_valid = 0; issue_tag = 0;
    exec_valid = 0; exec_tag = 0; exec_is_branch = 0; exec_taken = 0;
    exec_is_mem = 0; exec_dcmiss = 0; exec_mispredict = 0;
    done_valid = 0; done_tag = 0; done_retired = 0; sw_rearm = 0;
    #1;
    check("R10 irq one cycle after completion", 32'(irq), 32'd1);
    if (rearm_at_done) begin
      @(negedge clk); @(negedge clk); #1;
      check("R4 same-cycle rearm ignored, irq held", 32'(irq), 32'd1);
    end
    wait (popped == pushed);
  endtask

  // Monitor: on each new interrupt, pop the expected record and compare
  initial begin
    bit seen;
    rec_t e;
    seen = 0;
    forever begin
      @(negedge clk);
      #2;
      if (irq && !seen) begin
        seen = 1;
        if (sb_q.size() == 0) begin
          check("R10 unexpected interrupt", 32'd1, 32'd0);
        end else begin
          e = sb_q.pop_front();
          rd_sel = 2'd0; #1 check("R5 captured PC", rd_data, e.pc);
          rd_sel = 2'd1; #1 check("R6 data address", rd_data, e.daddr);
          rd_sel = 2'd2; #1 check("R6/R9 flags", rd_data, e.flags);
          rd_sel = 2'd3; #1 check("R7/R8 latencies", rd_data, e.lat);
          rd_sel = 2'd0;
        end
        popped++;
      end
      if (!irq) seen = 0;
    end
  end

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_sel = 2'd2; #1;
    check("R1 flags clear after reset", rd_data, 32'd0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      fetch_valid = 1; fetch_pc = 32'h2000 + 32'(4 * i);
      #1; if (fetch_tag || irq) bad++;
      @(negedge clk);
    end
    fetch_valid = 0;
    check("R1 no tag or irq before first rearm", 32'(bad), 32'd0);

    // R5 R6 R7: memory op, D-cache miss, retired
    run_sample(5, 0, 2, 3, 1, 4, 1, 0, 1, 1, 0, 0, 0, 32'hDEAD_0040, 0);
    // R2 R3 R6: gapped fetch, mispredicted taken branch, I-cache miss
    run_sample(9, 3, 1, 1, 2, 3, 1, 1, 0, 0, 1, 1, 1, 32'h0, 0);
    // R9: aborted after issue
    run_sample(3, 4, 2, 2, -1, 3, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0);
    // R8: retire latency saturates
    run_sample(2, 0, 1, 1, 1, 300, 1, 0, 1, 0, 0, 0, 0, 32'h0000_8888, 0);
    // R4: rearm in the completion cycle is ignored
    run_sample(4, 0, 3, 1, 1, 2, 1, 0, 0, 0, 1, 0, 0, 32'h0, 1);
    // R2 R9: zero base, aborted before map
    run_sample(0, 2, -1, -1, -1, 5, 0, 1, 0, 0, 0, 0, 0, 32'h0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule